// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Timer

This block keeps an external DRAM region refreshed. An 8-bit interval counter is clocked by a prescaled version of the system clock. When the counter reaches a programmable compare value, the counter clears and the block queues a refresh request. The queued request is served as a CAS-before-RAS cycle on active-low `ras_n` and `cas_n` outputs. Because CAS falls first, the DRAM refreshes from its internal row counter and no row address is needed.

Software uses a small register port to set the interval. It loads the counter and the compare value first, then writes a nonzero clock select to start counting. The block drives `hold_off` to the external bus arbiter. From the moment a request is queued until the refresh cycle ends, the arbiter grants no other external access. A refresh request waits for an access already in flight. A standby request puts the DRAM into self-refresh, with both strobes held low until the standby request is withdrawn.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the counter reads 0, the compare register reads 0xFF, the control register reads 0, `ras_n` and `cas_n` are 1, and `refresh_busy` and `hold_off` are 0.
- R2: Registers are selected by `reg_addr`: 0 = control (bit 7 refresh enable, bits 2:0 clock select, other bits read 0), 1 = counter, 2 = compare. A write takes effect at the clock edge where `reg_we` is high. `reg_rdata` shows the selected register in the same cycle.
- R3: While the clock select is 0, the counter does not advance.
- R4: Select values 1 to 7 advance the counter once every 2, 8, 32, 128, 512, 2048 or 4096 system clocks. The first advance comes that many clocks after the edge that wrote the select, when the select was 0 before.
- R5: When the counter equals the compare value at an advance, it becomes 0 instead of incrementing, and counting continues from 0.
- R6: A compare match queues a refresh only when the refresh enable bit is 1 and `dram_mode` is 1. Otherwise no strobe moves and `hold_off` stays 0.
- R7: A queued refresh runs as follows. `cas_n` goes low alone for 1 cycle. Then `cas_n` and `ras_n` are both low for 2 cycles. Then both are high for 1 precharge cycle. `refresh_busy` is 1 for all four cycles. `ras_n` is never low while `cas_n` is high. With no access in flight, the first cycle begins one clock after the matching edge.
- R8: `hold_off` is 1 from the edge that queues a refresh until its precharge cycle ends.
- R9: While `ext_access` is 1, a queued refresh does not start. It starts at the first edge where `ext_access` is 0.
- R10: A counter write at the same edge as a compare match loads the written value instead of 0.
- R11: When `standby_req` is 1 with `dram_mode` 1 and no refresh running, `cas_n` falls at the next edge and `ras_n` at the one after. Both stay low while `standby_req` stays 1. One precharge cycle with both high follows its removal. With `dram_mode` 0 a standby request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dram_mode | input | 1 | Target area is configured as DRAM space |
| ext_access | input | 1 | An external bus access is in progress |
| standby_req | input | 1 | Software standby request |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| refresh_busy | output | 1 | A refresh or self-refresh cycle is running |
| hold_off | output | 1 | Arbiter must grant no external access |

## Verification
A select write at edge E0 produces the first counter advance at E0 plus the divide ratio. A compare value C places the matching edge at E0 + (C+1) times the ratio. The strobe sequence starts one edge after that and moves one phase per edge. The bench drives every input on the falling clock edge and reads outputs and `reg_rdata` on a later falling edge. Each result is therefore checked exactly k edges after its stimulus, with k taken from these formulas. For each select value, the cycle at which `refresh_busy` first rises is compared with a precomputed count. Register reads, the write-versus-clear collision, the deferral by `ext_access` and the self-refresh phases are each sampled at the specific edge they fall on.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CAS, ST_RAS1, ST_RAS2, ST_PRE, ST_SR_CAS, ST_SR_HOLD
    } seq_state_e;

    // Power-of-two exponent of the divide ratio for each select code.
    function automatic logic [3:0] div_shift(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd1:    div_shift = 4'd1;
            3'd2:    div_shift = 4'd3;
            3'd3:    div_shift = 4'd5;
            3'd4:    div_shift = 4'd7;
            3'd5:    div_shift = 4'd9;
            3'd6:    div_shift = 4'd11;
            3'd7:    div_shift = 4'd12;
            default: div_shift = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/rfr_prescaler.sv
module rfr_prescaler
    import rfr_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask  = ~({PRE_W{1'b1}} << div_shift(sel));
        tick  = (sel != '0) && ((pre_q.div & mask) == mask);
        pre_d = pre_q;
        if (sel == '0) pre_d.div = '0;
        else           pre_d.div = pre_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3
    stopped_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> !tick);
endmodule

// File: rtl/rfr_interval.sv
module rfr_interval
    import rfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_we,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cmp,
    output logic              match
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] cmp;
    } ivl_t;

    ivl_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        match = tick && (r_q.cnt == r_q.cmp);
        if (tick) r_d.cnt = match ? '0 : r_q.cnt + 1'b1;
        if (cnt_we) r_d.cnt = wdata;   // software write wins over clear
        if (cmp_we) r_d.cmp = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.cmp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt = r_q.cnt;
    assign cmp = r_q.cmp;

    // R5
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cnt_we) |=> (cnt == '0));
    // R10
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt == $past(wdata)));
    // R3
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(cnt));
endmodule

// File: rtl/rfr_sequencer.sv
module rfr_sequencer
    import rfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ext_access,
    input  logic standby_req,
    input  logic dram_mode,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic hold_off
);
    typedef struct packed {
        seq_state_e st;
        logic       pending;
    } seq_t;

    seq_t r_d, r_q;
    logic start;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (standby_req && dram_mode)        r_d.st = ST_SR_CAS;
                else if (r_q.pending && !ext_access) begin
                    r_d.st = ST_CAS;
                    start  = 1'b1;
                end
            end
            ST_CAS:     r_d.st = ST_RAS1;
            ST_RAS1:    r_d.st = ST_RAS2;
            ST_RAS2:    r_d.st = ST_PRE;
            ST_PRE:     r_d.st = ST_IDLE;
            ST_SR_CAS:  r_d.st = ST_SR_HOLD;
            ST_SR_HOLD: if (!standby_req) r_d.st = ST_PRE;
            default:    r_d.st = ST_IDLE;
        endcase
        r_d.pending = req || (r_q.pending && !start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.pending <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cas_n = !(r_q.st inside {ST_CAS, ST_RAS1, ST_RAS2, ST_SR_CAS, ST_SR_HOLD});
        ras_n = !(r_q.st inside {ST_RAS1, ST_RAS2, ST_SR_HOLD});
        busy  = (r_q.st != ST_IDLE);
        hold_off = busy || r_q.pending;
    end

    // R7
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);
    // R7
    ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !$past(cas_n));
    // R7
    cbr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CAS) |=> (r_q.st == ST_RAS1));
    // R9
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && ext_access) |=> (r_q.st != ST_CAS));
    // R11
    self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_SR_HOLD) && standby_req) |=> (!ras_n && !cas_n));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import rfr_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dram_mode,
    input  logic              ext_access,
    input  logic              standby_req,
    output logic              ras_n,
    output logic              cas_n,
    output logic              refresh_busy,
    output logic              hold_off
);
    localparam int PAD_W = DATA_W - SEL_W - 1;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  tick, match, req, cnt_we, cmp_we;
    logic [DATA_W-1:0] cnt, cmp;

    always_comb begin
        ctl_d  = ctl_q;
        cnt_we = reg_we && (reg_addr == A_CNT);
        cmp_we = reg_we && (reg_addr == A_CMP);
        if (reg_we && (reg_addr == A_CTRL)) begin
            ctl_d.en  = reg_wdata[DATA_W-1];
            ctl_d.sel = reg_wdata[SEL_W-1:0];
        end
        req = match && ctl_q.en && dram_mode;
        case (reg_addr)
            A_CTRL:  reg_rdata = {ctl_q.en, {PAD_W{1'b0}}, ctl_q.sel};
            A_CNT:   reg_rdata = cnt;
            A_CMP:   reg_rdata = cmp;
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rfr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctl_q.sel),
        .tick  (tick)
    );

    rfr_interval u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_we (cnt_we),
        .cmp_we (cmp_we),
        .wdata  (reg_wdata),
        .cnt    (cnt),
        .cmp    (cmp),
        .match  (match)
    );

    rfr_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .ext_access  (ext_access),
        .standby_req (standby_req),
        .dram_mode   (dram_mode),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .busy        (refresh_busy),
        .hold_off    (hold_off)
    );

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> hold_off);
    // R6
    gated_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !(ctl_q.en && dram_mode)) |-> !req);
endmodule

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       dram_mode = 1'b1;
    logic       ext_access = 1'b0;
    logic       standby_req = 1'b0;
    logic       ras_n, cas_n, refresh_busy, hold_off;

    int checks = 0;
    int errors = 0;

    // {select, compare, negedges from write to first busy cycle = (cmp+1)*2^k + 1}
    localparam logic [31:0] VEC [7] = '{
        {8'd1, 8'd3, 16'd9},
        {8'd2, 8'd2, 16'd25},
        {8'd3, 8'd1, 16'd65},
        {8'd4, 8'd0, 16'd129},
        {8'd5, 8'd0, 16'd513},
        {8'd6, 8'd0, 16'd2049},
        {8'd7, 8'd1, 16'd8193}
    };

    always #4 clk = ~clk;

    dram_refresh_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dram_mode(dram_mode),
        .ext_access(ext_access), .standby_req(standby_req), .ras_n(ras_n),
        .cas_n(cas_n), .refresh_busy(refresh_busy), .hold_off(hold_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int k;
        step(3);
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 cnt", v, 8'h00);
        rd(2'd2, v); check("R1 cmp", v, 8'hFF);
        check("R1 strobes", {ras_n, cas_n, refresh_busy, hold_off}, 4'b1100);
        rst_n = 1'b1;
        step(1);

        // R2 register access, other ctrl bits read 0
        dram_mode = 1'b0;
        wr(2'd2, 8'h5A); rd(2'd2, v); check("R2 cmp", v, 8'h5A);
        wr(2'd1, 8'h33); rd(2'd1, v); check("R2 cnt", v, 8'h33);
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 ctrl", v, 8'h87);
        wr(2'd0, 8'h80); rd(2'd0, v); check("R2 ctrl en only", v, 8'h80);

        // R3 stopped counter
        wr(2'd1, 8'h05); step(50);
        rd(2'd1, v); check("R3 stopped", v, 8'h05);
        wr(2'd0, 8'h00);
        dram_mode = 1'b1;

        // R4 and R7 table walk
        for (int i = 0; i < 7; i++) begin
            wr(2'd2, VEC[i][23:16]);
            wr(2'd1, 8'h00);
            wr(2'd0, {1'b1, 4'b0, VEC[i][26:24]});
            k = 0;
            while (!refresh_busy && k < 20000) begin
                step(1); k++;
            end
            check("R4 interval", k, {16'd0, VEC[i][15:0]});
            check("R7 cas phase", {cas_n, ras_n, hold_off}, 3'b011);
            step(1); check("R7 ras phase 1", {cas_n, ras_n, refresh_busy}, 3'b001);
            step(1); check("R7 ras phase 2", {cas_n, ras_n, refresh_busy}, 3'b001);
            wr(2'd0, 8'h80);
            check("R7 precharge", {cas_n, ras_n, refresh_busy}, 3'b111);
            step(1); check("R7 done", refresh_busy, 1'b0);
            step(6);
        end

        // R5 clear on match, R6 refresh disabled
        wr(2'd2, 8'd2); wr(2'd1, 8'd0); wr(2'd0, 8'h01);
        step(5); rd(2'd1, v); check("R5 before match", v, 8'd2);
        step(1); rd(2'd1, v); check("R5 cleared", v, 8'd0);
        step(2); rd(2'd1, v); check("R5 resumes", v, 8'd1);
        check("R6 enable off", hold_off, 1'b0);
        dram_mode = 1'b0;
        wr(2'd0, 8'h81);
        k = 0;
        for (int j = 0; j < 20; j++) begin
            step(1);
            if (hold_off || !cas_n) k++;
        end
        check("R6 dram_mode off", k, 0);
        wr(2'd0, 8'h00);
        dram_mode = 1'b1;

        // R10 write beats clear
        wr(2'd2, 8'd3); wr(2'd1, 8'd0); wr(2'd0, 8'h01);
        step(7);
        wr(2'd1, 8'h40);
        rd(2'd1, v); check("R10 write wins", v, 8'h40);
        step(2); rd(2'd1, v); check("R10 continues", v, 8'h41);
        wr(2'd0, 8'h00);

        // R9 deferral and R8 hold-off
        ext_access = 1'b1;
        wr(2'd2, 8'd3); wr(2'd1, 8'd0); wr(2'd0, 8'h81);
        step(8);
        check("R8 hold on match", {hold_off, refresh_busy}, 2'b10);
        step(4);
        check("R9 deferred", {refresh_busy, cas_n}, 2'b01);
        ext_access = 1'b0;
        step(1);
        check("R9 starts", {refresh_busy, cas_n, hold_off}, 3'b101);
        wr(2'd0, 8'h80);
        step(12);
        check("R8 released", hold_off, 1'b0);

        // R11 self-refresh
        dram_mode = 1'b0;
        standby_req = 1'b1;
        step(3);
        check("R11 ignored w/o dram", {cas_n, refresh_busy}, 2'b10);
        standby_req = 1'b0;
        dram_mode = 1'b1;
        step(1);
        standby_req = 1'b1;
        step(1); check("R11 cas first", {cas_n, ras_n, refresh_busy}, 3'b011);
        step(1); check("R11 both low", {cas_n, ras_n}, 2'b00);
        step(5); check("R11 held", {cas_n, ras_n, hold_off}, 3'b001);
        standby_req = 1'b0;
        step(1); check("R11 precharge", {cas_n, ras_n, refresh_busy}, 3'b111);
        step(1); check("R11 idle", refresh_busy, 1'b0);

        finish_run();
    end
endmodule